// File: doc/BRIEF.md
# Four-Channel Fractional Clock-Enable Bank

This block turns one fast source clock into four independent clock-enable streams. Each stream's average rate is the source rate times 18 divided by a per-channel divisor between 18 and 35. Every channel keeps a small phase accumulator. On each source cycle the accumulator gains 18. Whenever it reaches the divisor, the channel emits a one-cycle enable pulse and the divisor is taken off the accumulator. Downstream logic qualifies its flops with these enables, so it can run anywhere from the full source rate down to just over half of it, with no second clock domain.

All four channels are set up through one 32-bit control word. Each byte of the word belongs to one channel and holds a divisor field and a gate-off bit. The word can be written in three ways. A plain write replaces it. A set-style write ORs ones into it. A clear-style write removes ones from it. The set and clear forms let one channel be retuned or gated without reading the word first. The current word is always visible on the readback port.

Top module: `fracclk_bank`

## Requirements
- R1: Channel n owns bits [8n+7:8n] of the control word. Bits [8n+5:8n] hold its divisor field. Bit 8n+7 is its gate-off bit (1 = stopped, 0 = running). Bit 8n+6 always reads 0 and cannot be written. `rd_data` shows the whole word from the cycle after the write edge.
- R2: After reset the word is 0x92929292: every channel is gated off with divisor 18. No `ce_out` bit pulses while its channel is gated.
- R3: A write with `wr_kind` = 2'b00 replaces every writable bit with `wr_data`.
- R4: `wr_kind` = 2'b01 sets exactly the bits that are 1 in `wr_data`, and `wr_kind` = 2'b10 clears exactly those bits. All other bits keep their value. `wr_kind` = 2'b11, or `wr_en` low, leaves the word unchanged.
- R5: A channel that starts from zero phase with effective divisor F drives `ce_out` high in cycle k after the opening write edge (k = 1, 2, ...) exactly when floor(18k/F) exceeds floor(18(k-1)/F). So 18 pulses arrive in every F cycles, and never more than one per cycle.
- R6: A divisor field below 18 acts as 18, and a field above 35 acts as 35.
- R7: When the gate-off bit is set, the output may still pulse in the cycle right after the write edge. From the next cycle on it stays low for as long as the gate stays off.
- R8: A gated channel's phase is cleared, so reopening the gate starts again from zero phase, as in R5.
- R9: A divisor change applies from the first edge after the write edge, and the accumulated phase carries over unchanged.
- R10: Each channel's output depends only on its own byte. Writing or running one channel does not change another channel's pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_kind | input | 2 | Write style: 00 replace, 01 set ones, 10 clear ones, 11 none |
| wr_data | input | 32 | Write data or bit mask |
| rd_data | output | 32 | Current control word |
| ce_out | output | 4 | One clock-enable stream per channel |

## Verification
The bench builds the block with its default parameters: four byte-wide lanes, a 6-bit divisor field, a numerator of 18 and limits of 18 and 35. With these values the longest pulse period is 35 cycles. That short period lets the bench compare every single cycle of at least two full periods against the floor formula for several divisors. It also compares all four channels at the same time with different divisors. Out-of-range fields, phase carry-over across a divisor change and the phase restart after gating can each be told apart from wrong behaviour within a handful of cycles.

// File: rtl/fcb_pkg.sv
package fcb_pkg;

  typedef enum logic [1:0] {
    WR_PLAIN = 2'b00,
    WR_SET   = 2'b01,
    WR_CLEAR = 2'b10,
    WR_NONE  = 2'b11
  } wr_kind_e;

  // Bound a raw divisor field into the legal window.
  function automatic int unsigned clamp_div(input int unsigned raw,
                                            input int unsigned lo,
                                            input int unsigned hi);
    if (raw < lo) return lo;
    if (raw > hi) return hi;
    return raw;
  endfunction

  // True when one more numerator step crosses the divisor.
  function automatic logic step_fires(input int unsigned phase,
                                      input int unsigned numer,
                                      input int unsigned divisor);
    return (phase + numer) >= divisor;
  endfunction

  // Phase left after one step, with or without a pulse.
  function automatic int unsigned step_phase(input int unsigned phase,
                                             input int unsigned numer,
                                             input int unsigned divisor);
    int unsigned total;
    total = phase + numer;
    if (total >= divisor) return total - divisor;
    return total;
  endfunction

endpackage

// File: rtl/fcb_ctrl_reg.sv
module fcb_ctrl_reg
  import fcb_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int LANE_W   = 8,
  parameter int FRAC_W   = 6,
  parameter int RST_FRAC = 18
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [1:0]                 wr_kind,
  input  logic [NUM_CH*LANE_W-1:0]   wr_data,
  output logic [NUM_CH*LANE_W-1:0]   ctrl_q
);
  localparam int REG_W  = NUM_CH * LANE_W;
  localparam int DEAD_W = LANE_W - 1 - FRAC_W;

  logic [REG_W-1:0] live_mask;
  logic [REG_W-1:0] rst_word;
  logic [REG_W-1:0] word_nxt;

  // Per-lane layout: gate-off on top, dead bits in between, divisor at bottom.
  for (genvar n = 0; n < NUM_CH; n++) begin : g_lane
    assign live_mask[n*LANE_W +: LANE_W] = {1'b1, {DEAD_W{1'b0}}, {FRAC_W{1'b1}}};
    assign rst_word[n*LANE_W +: LANE_W]  = {1'b1, {DEAD_W{1'b0}}, FRAC_W'(RST_FRAC)};
  end

  always_comb begin
    word_nxt = ctrl_q;
    if (wr_en) begin
      unique case (wr_kind_e'(wr_kind))
        WR_PLAIN: word_nxt = wr_data;
        WR_SET:   word_nxt = ctrl_q | wr_data;
        WR_CLEAR: word_nxt = ctrl_q & ~wr_data;
        default:  word_nxt = ctrl_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= rst_word;
    else        ctrl_q <= word_nxt & live_mask;
  end

endmodule

// File: rtl/fcb_lane_decode.sv
module fcb_lane_decode
  import fcb_pkg::*;
#(
  parameter int LANE_W   = 8,
  parameter int FRAC_W   = 6,
  parameter int FRAC_MIN = 18,
  parameter int FRAC_MAX = 35
) (
  input  logic [LANE_W-1:0] lane,
  output logic              gate_off,
  output logic [FRAC_W-1:0] frac_eff
);
  localparam int GATE_BIT = LANE_W - 1;

  assign gate_off = lane[GATE_BIT];
  assign frac_eff = FRAC_W'(clamp_div(32'(lane[FRAC_W-1:0]), FRAC_MIN, FRAC_MAX));

endmodule

// File: rtl/fcb_phase_acc.sv
module fcb_phase_acc
  import fcb_pkg::*;
#(
  parameter int FRAC_W = 6,
  parameter int NUMER  = 18,
  parameter int ACC_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gate_off,
  input  logic [FRAC_W-1:0] frac_eff,
  output logic              fire,
  output logic [ACC_W-1:0]  phase_q,
  output logic              ce
);
  logic [ACC_W-1:0] phase_nxt;

  assign fire      = step_fires(32'(phase_q), NUMER, 32'(frac_eff));
  assign phase_nxt = ACC_W'(step_phase(32'(phase_q), NUMER, 32'(frac_eff)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      ce      <= 1'b0;
    end else if (gate_off) begin
      phase_q <= '0;
      ce      <= 1'b0;
    end else begin
      phase_q <= phase_nxt;
      ce      <= fire;
    end
  end

endmodule

// File: rtl/fracclk_bank.sv
module fracclk_bank
  import fcb_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int LANE_W   = 8,
  parameter int FRAC_W   = 6,
  parameter int NUMER    = 18,
  parameter int FRAC_MIN = 18,
  parameter int FRAC_MAX = 35
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [1:0]                wr_kind,
  input  logic [NUM_CH*LANE_W-1:0]  wr_data,
  output logic [NUM_CH*LANE_W-1:0]  rd_data,
  output logic [NUM_CH-1:0]         ce_out
);
  localparam int REG_W = NUM_CH * LANE_W;
  localparam int ACC_W = $clog2(FRAC_MAX + NUMER);

  // Named internal events for the checker.
  logic [REG_W-1:0]              ctrl_q;
  logic [NUM_CH-1:0]             lane_gate_off;
  logic [NUM_CH-1:0][FRAC_W-1:0] lane_frac;
  logic [NUM_CH-1:0][ACC_W-1:0]  lane_acc;
  logic [NUM_CH-1:0]             lane_fire;

  fcb_ctrl_reg #(
    .NUM_CH  (NUM_CH),
    .LANE_W  (LANE_W),
    .FRAC_W  (FRAC_W),
    .RST_FRAC(FRAC_MIN)
  ) u_reg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_kind(wr_kind),
    .wr_data(wr_data),
    .ctrl_q (ctrl_q)
  );

  assign rd_data = ctrl_q;

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    fcb_lane_decode #(
      .LANE_W  (LANE_W),
      .FRAC_W  (FRAC_W),
      .FRAC_MIN(FRAC_MIN),
      .FRAC_MAX(FRAC_MAX)
    ) u_dec (
      .lane    (ctrl_q[n*LANE_W +: LANE_W]),
      .gate_off(lane_gate_off[n]),
      .frac_eff(lane_frac[n])
    );

    fcb_phase_acc #(
      .FRAC_W(FRAC_W),
      .NUMER (NUMER),
      .ACC_W (ACC_W)
    ) u_acc (
      .clk     (clk),
      .rst_n   (rst_n),
      .gate_off(lane_gate_off[n]),
      .frac_eff(lane_frac[n]),
      .fire    (lane_fire[n]),
      .phase_q (lane_acc[n]),
      .ce      (ce_out[n])
    );
  end

endmodule

// File: rtl/fcb_checker.sv
module fcb_checker #(
  parameter int NUM_CH   = 4,
  parameter int LANE_W   = 8,
  parameter int FRAC_W   = 6,
  parameter int FRAC_MAX = 35,
  parameter int ACC_W    = 6
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      wr_en,
  input logic [1:0]                wr_kind,
  input logic [NUM_CH*LANE_W-1:0]  wr_data,
  input logic [NUM_CH*LANE_W-1:0]  ctrl_q,
  input logic [NUM_CH-1:0]         ce_out,
  input logic [NUM_CH-1:0]         lane_gate_off,
  input logic [NUM_CH-1:0][ACC_W-1:0] lane_acc,
  input logic [NUM_CH-1:0]         lane_fire
);
  localparam int REG_W  = NUM_CH * LANE_W;
  localparam int DEAD_W = LANE_W - 1 - FRAC_W;

  logic [REG_W-1:0] chk_live;
  logic [REG_W-1:0] set_bits;

  for (genvar n = 0; n < NUM_CH; n++) begin : g_mask
    assign chk_live[n*LANE_W +: LANE_W] = {1'b1, {DEAD_W{1'b0}}, {FRAC_W{1'b1}}};
  end
  assign set_bits = wr_data & chk_live;

  AST_SET_ALIAS_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_kind == 2'b01) |=> ((ctrl_q & $past(set_bits)) == $past(set_bits))); // R4

  AST_CLEAR_ALIAS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_kind == 2'b10) |=> ((ctrl_q & $past(wr_data)) == '0)); // R4

  AST_IDLE_WORD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || wr_kind == 2'b11) |=> $stable(ctrl_q)); // R4

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    AST_DEAD_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_q[n*LANE_W+FRAC_W +: DEAD_W] == '0); // R1

    AST_GATED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      $past(lane_gate_off[n]) |-> !ce_out[n]); // R7

    AST_GATED_PHASE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $past(lane_gate_off[n]) |-> (lane_acc[n] == '0)); // R8

    AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      32'(lane_acc[n]) < FRAC_MAX); // R5

    AST_FIRE_REACHES_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      (!lane_gate_off[n] && lane_fire[n]) |=> ce_out[n]); // R5
  end

endmodule

bind fracclk_bank fcb_checker #(
  .NUM_CH  (NUM_CH),
  .LANE_W  (LANE_W),
  .FRAC_W  (FRAC_W),
  .FRAC_MAX(FRAC_MAX),
  .ACC_W   (ACC_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en        (wr_en),
  .wr_kind      (wr_kind),
  .wr_data      (wr_data),
  .ctrl_q       (ctrl_q),
  .ce_out       (ce_out),
  .lane_gate_off(lane_gate_off),
  .lane_acc     (lane_acc),
  .lane_fire    (lane_fire)
);

// File: tb/sim_fracclk_bank.sv
`timescale 1ns/1ps
module sim_fracclk_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_kind = 2'b00;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [3:0]  ce_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  fracclk_bank u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(wr_kind),
    .wr_data(wr_data), .rd_data(rd_data), .ce_out(ce_out)
  );

  function automatic logic [7:0] lane(input bit off, input int f);
    return {off, 1'b0, 6'(f)};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Drive at a falling edge; returns at the falling edge after the write edge.
  task automatic do_write(input logic [1:0] kind, input logic [31:0] data);
    wr_en = 1'b1; wr_kind = kind; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0; wr_kind = 2'b00; wr_data = '0;
  endtask

  function automatic int expect_pulse(input int k, input int f);
    return ((18 * k) / f) - ((18 * (k - 1)) / f);
  endfunction

  task automatic run_rate(input int ch, input int f, input int ncyc, input string req);
    for (int k = 1; k <= ncyc; k++) begin
      logic [3:0] others;
      @(negedge clk);
      others = ce_out;
      others[ch] = 1'b0;
      chk(req, 32'(ce_out[ch]), 32'(expect_pulse(k, f)));
      chk("R10 other channels idle", 32'(others), 32'd0);
    end
  endtask

  task automatic gate_all();
    do_write(2'b00, 32'h92929292);
  endtask

  task automatic t_reset();
    chk("R2 reset word", rd_data, 32'h92929292);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R2 no pulses after reset", 32'(ce_out), 32'd0);
    end
  endtask

  task automatic t_plain();
    do_write(2'b00, 32'hFFFFFFFF);
    chk("R1 R3 dead bits read zero", rd_data, 32'hBFBFBFBF);
    do_write(2'b00, 32'h12345678);
    chk("R3 plain replace", rd_data, 32'h12341638);
    gate_all();
    chk("R3 plain regate", rd_data, 32'h92929292);
  endtask

  task automatic t_rates();
    int fl[4] = '{18, 24, 27, 35};
    foreach (fl[i]) begin
      gate_all();
      do_write(2'b00, {lane(1,18), lane(1,18), lane(1,18), lane(0, fl[i])});
      run_rate(0, fl[i], 2 * fl[i], "R5 pulse pattern");
    end
  endtask

  task automatic t_clamp();
    gate_all();
    do_write(2'b00, {24'h929292, lane(0, 5)});
    run_rate(0, 18, 20, "R6 low field acts as 18");
    gate_all();
    do_write(2'b00, {24'h929292, lane(0, 17)});
    run_rate(0, 18, 20, "R6 field 17 acts as 18");
    gate_all();
    do_write(2'b00, {24'h929292, lane(0, 63)});
    run_rate(0, 35, 70, "R6 high field acts as 35");
  endtask

  task automatic t_multi();
    int fm[4] = '{18, 24, 30, 35};
    gate_all();
    do_write(2'b00, {lane(0, fm[3]), lane(0, fm[2]), lane(0, fm[1]), lane(0, fm[0])});
    for (int k = 1; k <= 70; k++) begin
      @(negedge clk);
      for (int c = 0; c < 4; c++)
        chk("R10 R5 concurrent channels", 32'(ce_out[c]), 32'(expect_pulse(k, fm[c])));
    end
    gate_all();
  endtask

  task automatic t_alias();
    @(negedge clk);
    @(negedge clk);
    do_write(2'b10, 32'h00008000);
    chk("R4 clear alias opens ch1", rd_data, 32'h92921292);
    do_write(2'b01, 32'h00000001);
    chk("R4 set alias one bit", rd_data, 32'h92921293);
    do_write(2'b10, 32'h00000200);
    chk("R4 clear alias one bit", rd_data, 32'h92921093);
    do_write(2'b01, 32'h00000040);
    chk("R1 dead bit ignores set", rd_data, 32'h92921093);
    do_write(2'b11, 32'hFFFFFFFF);
    chk("R4 kind 11 no effect", rd_data, 32'h92921093);
    wr_data = 32'hFFFFFFFF;
    @(negedge clk);
    wr_data = '0;
    chk("R4 no strobe no effect", rd_data, 32'h92921093);
    chk("R6 R4 ch1 at full rate", 32'(ce_out), 32'h2);
  endtask

  task automatic t_gate_stop();
    do_write(2'b01, 32'h00008000);
    chk("R7 pulse allowed right after write", 32'(ce_out[1]), 32'd1);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      chk("R7 gated output low", 32'(ce_out), 32'd0);
    end
  endtask

  task automatic t_restart();
    do_write(2'b00, {24'h929292, lane(0, 27)});
    run_rate(0, 27, 4, "R5 partial run");
    do_write(2'b01, 32'h00000080);
    repeat (3) @(negedge clk);
    do_write(2'b10, 32'h00000080);
    run_rate(0, 27, 27, "R8 restart from zero phase");
    do_write(2'b01, 32'h00000080);
    @(negedge clk);
  endtask

  task automatic t_frac_keep();
    int exp_seq[6] = '{1, 1, 1, 1, 0, 1};
    do_write(2'b10, 32'h00000080);      // ch0 open, divisor 27
    @(negedge clk);
    chk("R9 first step", 32'(ce_out[0]), 32'd0);
    do_write(2'b00, {24'h929292, lane(0, 20)});
    chk("R9 old divisor on write edge", 32'(ce_out[0]), 32'd1);
    // hand-derived: phase 9 carried, then divisor 20 each edge
    foreach (exp_seq[i]) begin
      @(negedge clk);
      chk("R9 phase carries over", 32'(ce_out[0]), 32'(exp_seq[i]));
    end
    gate_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL all: watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_rates();
    t_clamp();
    t_multi();
    t_alias();
    t_gate_stop();
    t_restart();
    t_frac_keep();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule